// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block takes over the memory bus of a small 8-bit processor (16-bit address space) while an exception is being entered or left. The processor core tells it, cycle by cycle, which cycle is the second-to-last of the current instruction and which is the last. At each instruction boundary the block decides whether a power-on or requested restart, a non-maskable request, a maskable request, a software break opcode or a return-from-interrupt opcode is to be handled. It then owns the bus for a fixed number of cycles.

On entry it stores the return address and the status byte on the stack page, reads a two-byte vector from the top of memory and hands the new program counter, status and stack pointer back to the core in one load cycle. The return sequence reads the saved status and address back from the stack and hands them back the same way. The core keeps its own registers and the decoder. This block only uses their values at the boundary and loads them back at the end.

Memory reads are asynchronous: `rdata` must reflect `addr` within the same cycle. Writes take effect at the clock edge that ends a cycle with `we` high. Each instruction lasts at least two cycles.

Top module: `intr_sequencer`

## Requirements
- R1: While `rst` is high, `busy` is 1 and `we` is 0. After release, the block reads FFFC (low byte) and then FFFD (high byte), with no stack write and `sp_load` low. In the second cycle it pulses `pc_load` with that address and `p_out` = 8'h24. A `reset_req` seen at a boundary runs the same two-cycle fetch and sets bit 2 of `p_out`.
- R2: A maskable request (`irq_n` low) is taken at a boundary only if, when the second-to-last cycle ends, the line was already low and status bit 2 (mask) of `p_in` was 0. A masked request produces no bus activity at all.
- R3: A non-maskable request is taken whatever the mask bit is. Its vector is read little-endian: low byte from FFFA, then high byte from FFFB.
- R4: Maskable requests and the break opcode both vector through FFFE/FFFF. The pushed status has bit 4 set to 1 for a break and 0 for a hardware request, and bit 5 is always 1.
- R5: Entry writes PC[15:8] to {01,SP}, then PC[7:0] to {01,SP-1}, then the status to {01,SP-2}. It is busy for 5 cycles, and the load pulse comes in the last of them with `sp_out` = SP-3.
- R6: Every entry sets bit 2 in `p_out` during the load pulse.
- R7: On the return opcode, the block reads the status from {01,SP+1}, PC[7:0] from {01,SP+2} and PC[15:8] from {01,SP+3}. It is busy for 3 cycles, performs no write, and loads those values with `sp_out` = SP+3.
- R8: A maskable request that first appears in the second-to-last cycle of an instruction is not taken at that boundary. It is taken at the next boundary.
- R9: The non-maskable input is edge-triggered. A falling edge gives exactly one service however long the line stays low.
- R10: When several requests meet at a boundary, the order is restart, then non-maskable, then maskable, then break, then return. A non-maskable edge that loses to a restart stays pending and is taken at the following boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the restart vector fetch |
| irq_n | input | 1 | Maskable request, active low, level |
| nmi_n | input | 1 | Non-maskable request, active low, falling edge |
| reset_req | input | 1 | Restart request, taken at the next boundary |
| insn_penult | input | 1 | Core is in the second-to-last cycle of an instruction |
| insn_end | input | 1 | Core is in the last cycle of an instruction |
| brk_op | input | 1 | Next opcode is a software break |
| rti_op | input | 1 | Next opcode is a return from interrupt |
| pc_in | input | 16 | Return address offered by the core |
| p_in | input | 8 | Core status byte |
| sp_in | input | 8 | Core stack pointer |
| rdata | input | 8 | Read data for `addr`, same cycle |
| addr | output | 16 | Bus address while busy |
| wdata | output | 8 | Write data |
| we | output | 1 | Write enable |
| busy | output | 1 | Sequencer owns the bus |
| pc_load | output | 1 | Load `pc_out` into the core PC |
| pc_out | output | 16 | New program counter |
| p_load | output | 1 | Load `p_out` into the core status |
| p_out | output | 8 | New status byte |
| sp_load | output | 1 | Load `sp_out` into the core stack pointer |
| sp_out | output | 8 | New stack pointer |

## Verification
A wrong state register or a wrong saved event kind shows up at the latest at the load pulse. The bus then carries the wrong vector address or page, and the stack writes arrive out of order or with the wrong break bit. Those writes are visible one cycle after the boundary. A stale or missing request arm is only visible at the next instruction boundary, as a missing or extra entry, so the bench runs back-to-back instructions and checks both boundaries. Push and pull addresses are compared against a bench-side memory, so an off-by-one in the stack pointer shows up as a wrong restored address.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;

    localparam int AW = 16;
    localparam int DW = 8;

    localparam int I_BIT = 2;
    localparam int B_BIT = 4;
    localparam int U_BIT = 5;

    localparam logic [DW-1:0] I_MASK  = 8'b1 << I_BIT;
    localparam logic [DW-1:0] B_MASK  = 8'b1 << B_BIT;
    localparam logic [DW-1:0] U_MASK  = 8'b1 << U_BIT;
    localparam logic [DW-1:0] P_BOOT  = U_MASK | I_MASK;

    localparam logic [AW-1:0] VEC_NMI = 16'hFFFA;
    localparam logic [AW-1:0] VEC_RST = 16'hFFFC;
    localparam logic [AW-1:0] VEC_IRQ = 16'hFFFE;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PUSH_PCH,
        ST_PUSH_PCL,
        ST_PUSH_P,
        ST_VEC_LO,
        ST_VEC_HI,
        ST_PULL_P,
        ST_PULL_PCL,
        ST_PULL_PCH
    } seq_state_t;

    typedef enum logic [2:0] {
        EV_RESET,
        EV_NMI,
        EV_IRQ,
        EV_BRK,
        EV_RTI,
        EV_NONE
    } event_t;

    typedef struct packed {
        logic res;
        logic nmi;
        logic irq;
    } req_t;

    // Fixed order: restart, non-maskable, maskable, break, return
    function automatic event_t pick_event(req_t r, logic brk, logic rti);
        if (r.res)      return EV_RESET;
        else if (r.nmi) return EV_NMI;
        else if (r.irq) return EV_IRQ;
        else if (brk)   return EV_BRK;
        else if (rti)   return EV_RTI;
        else            return EV_NONE;
    endfunction

    function automatic logic [AW-1:0] vector_base(event_t ev);
        case (ev)
            EV_RESET: return VEC_RST;
            EV_NMI:   return VEC_NMI;
            default:  return VEC_IRQ;
        endcase
    endfunction

    function automatic logic [DW-1:0] push_status(logic [DW-1:0] p, logic is_brk);
        return (p & ~B_MASK) | U_MASK | (is_brk ? B_MASK : '0);
    endfunction

endpackage

// File: rtl/intr_req_sampler.sv
module intr_req_sampler
    import intr_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic irq_n,
    input  logic nmi_n,
    input  logic reset_req,
    input  logic penult,
    input  logic i_flag,
    input  logic bound,
    input  logic take_nmi,
    output req_t req
);

    logic irq_q, nmi_q, nmi_q2, res_q;
    logic nmi_pend, nmi_arm, irq_arm;
    logic nmi_edge;

    assign nmi_edge = nmi_q & ~nmi_q2;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q    <= 1'b0;
            nmi_q    <= 1'b0;
            nmi_q2   <= 1'b0;
            res_q    <= 1'b0;
            nmi_pend <= 1'b0;
            nmi_arm  <= 1'b0;
            irq_arm  <= 1'b0;
        end else begin
            irq_q    <= ~irq_n;
            nmi_q    <= ~nmi_n;
            nmi_q2   <= nmi_q;
            res_q    <= reset_req;
            nmi_pend <= (nmi_pend & ~take_nmi) | nmi_edge;
            if (bound) begin
                nmi_arm <= 1'b0;
                irq_arm <= 1'b0;
            end else if (penult) begin
                // only what was visible before this cycle counts
                nmi_arm <= nmi_pend | nmi_edge;
                irq_arm <= irq_q & ~i_flag;
            end
        end
    end

    assign req = '{res: res_q, nmi: nmi_arm, irq: irq_arm};

endmodule

// File: rtl/intr_entry_fsm.sv
module intr_entry_fsm
    import intr_seq_pkg::*;
#(
    parameter logic [7:0] STACK_PAGE = 8'h01
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          insn_end,
    input  req_t          req,
    input  logic          brk_op,
    input  logic          rti_op,
    input  logic [AW-1:0] pc_in,
    input  logic [DW-1:0] p_in,
    input  logic [7:0]    sp_in,
    input  logic [DW-1:0] rdata,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata,
    output logic          we,
    output logic          busy,
    output logic          pc_load,
    output logic [AW-1:0] pc_out,
    output logic          p_load,
    output logic [DW-1:0] p_out,
    output logic          sp_load,
    output logic [7:0]    sp_out,
    output logic          bound,
    output logic          take_nmi
);

    seq_state_t    state;
    event_t        kind;
    event_t        ev;
    logic [AW-1:0] pc_sv;
    logic [DW-1:0] p_sv;
    logic [7:0]    sp_w;
    logic [7:0]    sp_up;

    assign bound    = (state == ST_IDLE) && insn_end;
    assign ev       = pick_event(req, brk_op, rti_op);
    assign take_nmi = bound && (ev == EV_NMI);
    assign sp_up    = sp_w + 8'd1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_VEC_LO;
            kind  <= EV_RESET;
            pc_sv <= '0;
            p_sv  <= P_BOOT;
            sp_w  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (bound && ev != EV_NONE) begin
                        kind  <= ev;
                        pc_sv <= pc_in;
                        p_sv  <= p_in;
                        sp_w  <= sp_in;
                        if (ev == EV_RESET)    state <= ST_VEC_LO;
                        else if (ev == EV_RTI) state <= ST_PULL_P;
                        else                   state <= ST_PUSH_PCH;
                    end
                end
                ST_PUSH_PCH: begin sp_w <= sp_w - 8'd1; state <= ST_PUSH_PCL; end
                ST_PUSH_PCL: begin sp_w <= sp_w - 8'd1; state <= ST_PUSH_P;   end
                ST_PUSH_P:   begin sp_w <= sp_w - 8'd1; state <= ST_VEC_LO;   end
                ST_VEC_LO:   begin pc_sv[7:0] <= rdata; state <= ST_VEC_HI;   end
                ST_VEC_HI:   state <= ST_IDLE;
                ST_PULL_P:   begin p_sv <= rdata; sp_w <= sp_up; state <= ST_PULL_PCL; end
                ST_PULL_PCL: begin pc_sv[7:0] <= rdata; sp_w <= sp_up; state <= ST_PULL_PCH; end
                ST_PULL_PCH: state <= ST_IDLE;
                default:     state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        addr    = '0;
        wdata   = '0;
        we      = 1'b0;
        busy    = (state != ST_IDLE);
        pc_load = 1'b0;
        p_load  = 1'b0;
        sp_load = 1'b0;
        pc_out  = pc_sv;
        p_out   = p_sv;
        sp_out  = sp_w;
        case (state)
            ST_PUSH_PCH: begin addr = {STACK_PAGE, sp_w}; wdata = pc_sv[15:8]; we = 1'b1; end
            ST_PUSH_PCL: begin addr = {STACK_PAGE, sp_w}; wdata = pc_sv[7:0];  we = 1'b1; end
            ST_PUSH_P: begin
                addr  = {STACK_PAGE, sp_w};
                wdata = push_status(p_sv, kind == EV_BRK);
                we    = 1'b1;
            end
            ST_VEC_LO: addr = vector_base(kind);
            ST_VEC_HI: begin
                addr    = vector_base(kind) | 16'd1;
                pc_load = 1'b1;
                pc_out  = {rdata, pc_sv[7:0]};
                p_load  = 1'b1;
                p_out   = p_sv | I_MASK;
                sp_load = (kind != EV_RESET);
            end
            ST_PULL_P, ST_PULL_PCL: addr = {STACK_PAGE, sp_up};
            ST_PULL_PCH: begin
                addr    = {STACK_PAGE, sp_up};
                pc_load = 1'b1;
                pc_out  = {rdata, pc_sv[7:0]};
                p_load  = 1'b1;
                sp_load = 1'b1;
                sp_out  = sp_up;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/intr_sequencer.sv
module intr_sequencer
    import intr_seq_pkg::*;
#(
    parameter logic [7:0] STACK_PAGE = 8'h01
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          irq_n,
    input  logic          nmi_n,
    input  logic          reset_req,
    input  logic          insn_penult,
    input  logic          insn_end,
    input  logic          brk_op,
    input  logic          rti_op,
    input  logic [AW-1:0] pc_in,
    input  logic [DW-1:0] p_in,
    input  logic [7:0]    sp_in,
    input  logic [DW-1:0] rdata,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata,
    output logic          we,
    output logic          busy,
    output logic          pc_load,
    output logic [AW-1:0] pc_out,
    output logic          p_load,
    output logic [DW-1:0] p_out,
    output logic          sp_load,
    output logic [7:0]    sp_out
);

    req_t req;
    logic bound, take_nmi;

    intr_req_sampler u_sampler (
        .clk       (clk),
        .rst       (rst),
        .irq_n     (irq_n),
        .nmi_n     (nmi_n),
        .reset_req (reset_req),
        .penult    (insn_penult),
        .i_flag    (p_in[I_BIT]),
        .bound     (bound),
        .take_nmi  (take_nmi),
        .req       (req)
    );

    intr_entry_fsm #(.STACK_PAGE(STACK_PAGE)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .insn_end (insn_end),
        .req      (req),
        .brk_op   (brk_op),
        .rti_op   (rti_op),
        .pc_in    (pc_in),
        .p_in     (p_in),
        .sp_in    (sp_in),
        .rdata    (rdata),
        .addr     (addr),
        .wdata    (wdata),
        .we       (we),
        .busy     (busy),
        .pc_load  (pc_load),
        .pc_out   (pc_out),
        .p_load   (p_load),
        .p_out    (p_out),
        .sp_load  (sp_load),
        .sp_out   (sp_out),
        .bound    (bound),
        .take_nmi (take_nmi)
    );

endmodule

// File: rtl/intr_sequencer_chk.sv
module intr_sequencer_chk #(
    parameter logic [7:0] STACK_PAGE = 8'h01
) (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        we,
    input logic        pc_load,
    input logic [15:0] addr,
    input logic        i_out
);

    // R5
    stack_write_page_chk: assert property (@(posedge clk) disable iff (rst)
        we |-> (busy && addr[15:8] == STACK_PAGE));

    // R6
    entry_sets_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (pc_load && addr[15:8] == 8'hFF) |-> i_out);

    // R3
    vector_low_first_chk: assert property (@(posedge clk) disable iff (rst)
        (pc_load && addr[15:8] == 8'hFF) |-> (addr[0] && $past(addr) == addr - 16'd1));

    // R5
    load_ends_busy_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(pc_load));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!we && !pc_load));

endmodule

bind intr_sequencer intr_sequencer_chk #(.STACK_PAGE(STACK_PAGE)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .we      (we),
    .pc_load (pc_load),
    .addr    (addr),
    .i_out   (p_out[2])
);

// File: tb/sim_intr_sequencer.sv
module sim_intr_sequencer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        irq_n = 1'b1, nmi_n = 1'b1, reset_req = 1'b0;
    logic        insn_penult = 1'b0, insn_end = 1'b0, brk_op = 1'b0, rti_op = 1'b0;
    logic [15:0] pc_in = 16'h0000;
    logic [7:0]  p_in = 8'h20, sp_in = 8'hFF, rdata;
    logic [15:0] addr, pc_out;
    logic [7:0]  wdata, p_out, sp_out;
    logic        we, busy, pc_load, p_load, sp_load;

    always #2.5 clk = ~clk;

    intr_sequencer u0 (.*);

    // bench memory: stack page plus vector bytes
    logic [7:0] stk [0:255];
    always_comb begin
        if (addr[15:8] == 8'h01) rdata = stk[addr[7:0]];
        else case (addr)
            16'hFFFA: rdata = 8'h11;
            16'hFFFB: rdata = 8'h90;
            16'hFFFC: rdata = 8'h22;
            16'hFFFD: rdata = 8'h80;
            16'hFFFE: rdata = 8'h33;
            16'hFFFF: rdata = 8'hA0;
            default:  rdata = 8'hEA;
        endcase
    end
    always @(posedge clk) if (we && addr[15:8] == 8'h01) stk[addr[7:0]] <= wdata;

    // observation, one time step after each edge
    int          nw, n_load, n_busy;
    logic [15:0] wa [0:7];
    logic [7:0]  wd [0:7];
    logic [15:0] g_pc;
    logic [7:0]  g_p, g_sp;
    logic        g_spl;
    always @(posedge clk) begin
        #1;
        if (we && nw < 8) begin wa[nw] = addr; wd[nw] = wdata; end
        if (we) nw++;
        if (busy) n_busy++;
        if (pc_load) begin
            n_load++; g_pc = pc_out; g_p = p_out; g_sp = sp_out; g_spl = sp_load;
        end
    end

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_log();
        nw = 0; n_load = 0; n_busy = 0;
    endtask

    task automatic run_insn(input bit late_irq);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            insn_penult = (c == 1);
            insn_end    = (c == 2);
            if (late_irq && c == 1) irq_n = 1'b0;
        end
        @(negedge clk);
        insn_penult = 1'b0;
        insn_end    = 1'b0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 20 && busy; k++) @(negedge clk);
    endtask

    typedef struct packed {
        logic        irq;
        logic        nmi;
        logic        brk;
        logic        ibit;
        logic        take;
        logic [15:0] pc;
        logic        b;
    } vec_t;

    localparam vec_t TBL [7] = '{
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 16'hA033, 1'b0},  // maskable, unmasked
        '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0},  // maskable, masked
        '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 16'h9011, 1'b0},  // non-maskable under mask
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 16'hA033, 1'b1},  // break
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 16'h9011, 1'b0},  // both lines
        '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 16'hA033, 1'b0},  // maskable beats break
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0}   // nothing
    };

    initial begin
        for (int a = 0; a < 256; a++) stk[a] = 8'h00;
        clear_log();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 busy in reset", busy, 1);
        check("R1 no write in reset", we, 0);
        clear_log();
        rst = 1'b0;
        wait_idle();
        check("R1 reset loads", n_load, 1);
        check("R1 reset pc", g_pc, 16'h8022);
        check("R1 reset status", g_p, 8'h24);
        check("R1 reset no writes", nw, 0);
        check("R1 reset sp untouched", g_spl, 0);

        for (int i = 0; i < 7; i++) begin
            vec_t e = TBL[i];
            string tg = e.nmi ? "R3" : ((e.brk && !e.irq) ? "R4" : "R2");
            logic [15:0] rpc = 16'h4000 + 16'(i) * 16'h0111;
            logic [7:0] pin = 8'h20 | (8'(e.ibit) << 2);
            @(negedge clk);
            clear_log();
            irq_n = ~e.irq; nmi_n = ~e.nmi; brk_op = e.brk;
            p_in = pin; pc_in = rpc; sp_in = 8'hFF;
            run_insn(1'b0);
            brk_op = 1'b0;
            wait_idle();
            irq_n = 1'b1; nmi_n = 1'b1;
            check({tg, " taken"}, n_load, e.take);
            if (e.take) begin
                check({tg, " vector"}, g_pc, e.pc);
                check("R5 write count", nw, 3);
                check("R5 push pch", {wa[0], wd[0]}, {16'h01FF, rpc[15:8]});
                check("R5 push pcl", {wa[1], wd[1]}, {16'h01FE, rpc[7:0]});
                check("R4 push status", {wa[2], wd[2]}, {16'h01FD, pin | (8'(e.b) << 4)});
                check("R6 mask set", g_p[2], 1);
                check("R5 sp out", {g_spl, g_sp}, {1'b1, 8'hFC});
                check("R5 busy cycles", n_busy, 5);
            end else begin
                check({tg, " no bus activity"}, nw + n_busy, 0);
            end
            repeat (2) @(negedge clk);
        end

        // R8: request shows up only in the second-to-last cycle
        p_in = 8'h20; pc_in = 16'h5000;
        clear_log();
        run_insn(1'b1);
        wait_idle();
        check("R8 late request deferred", n_load, 0);
        run_insn(1'b0);
        wait_idle();
        irq_n = 1'b1;
        check("R8 taken one instruction later", n_load, 1);
        check("R8 vector", g_pc, 16'hA033);

        // R9: held non-maskable line gives one service
        repeat (2) @(negedge clk);
        clear_log();
        nmi_n = 1'b0;
        run_insn(1'b0);
        wait_idle();
        check("R9 first service", n_load, 1);
        clear_log();
        run_insn(1'b0);
        wait_idle();
        check("R9 no second service", n_load + nw, 0);
        nmi_n = 1'b1;

        // R7: return sequence
        repeat (2) @(negedge clk);
        stk[8'hFD] = 8'hC3; stk[8'hFE] = 8'h78; stk[8'hFF] = 8'h56;
        sp_in = 8'hFC;
        clear_log();
        rti_op = 1'b1;
        run_insn(1'b0);
        rti_op = 1'b0;
        wait_idle();
        check("R7 pc restored", g_pc, 16'h5678);
        check("R7 status restored", g_p, 8'hC3);
        check("R7 sp", {g_spl, g_sp}, {1'b1, 8'hFF});
        check("R7 no writes", nw, 0);
        check("R7 busy cycles", n_busy, 3);

        // R10: restart beats non-maskable, which stays pending
        sp_in = 8'hFF; p_in = 8'h20;
        clear_log();
        reset_req = 1'b1; nmi_n = 1'b0;
        run_insn(1'b0);
        reset_req = 1'b0;
        wait_idle();
        check("R10 restart wins", g_pc, 16'h8022);
        check("R10 restart no writes", nw, 0);
        check("R1 requested restart sets mask", g_p[2], 1);
        nmi_n = 1'b1;
        clear_log();
        run_insn(1'b0);
        wait_idle();
        check("R10 pending non-maskable next", {n_load[7:0], g_pc}, {8'd1, 16'h9011});

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(5ns * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule